// File: doc/BRIEF.md
# Store-and-Forward Router Node

This block is one node of a point-to-point packet network. It has one input and one output stream for the local host, and one pair for each neighbour link. Every packet has the same fixed number of beats. Its first beat is a header that carries the destination node number and a hop count. A packet is taken in whole and held in a slot of its input before any of it moves on. Packets addressed to this node go to the host output. All other packets go to the link that a fixed next-hop table names for their destination.

Each input owns one packet slot per buffer class. The class is the hop count the packet has made so far, capped at the top class. A header is refused while its class slot on that input is occupied, so a packet can only ever wait on a slot of a higher class downstream. Each output serves all full slots that route to it. It picks among inputs in round-robin order and streams the chosen packet beat by beat. On link outputs it bumps the hop count in the header. Packets that share an input and a class leave in arrival order, so a fixed route over in-order links keeps messages in order.

Every stream uses valid/ready. A beat moves on a clock edge where both are high. A sender must hold valid and data steady until that edge. The node may lower in_ready for a header because of the header's own class, so ready depends on the data presented. Once valid is high on an output, the node holds the beat steady until the receiver takes it. The node and the table port are plain pins.

Top module: `router_node`

## Requirements
- R1: A packet is PKT_BEATS beats of DATA_W bits. Beat 0 is the header: destination in bits [ID_W-1:0], hop count in bits [ID_W+HOP_W-1:ID_W]. All other header bits and all later beats pass through unchanged.
- R2: A packet whose destination equals node_id leaves on output N_LINK (the host output) with every beat unchanged.
- R3: Any other packet leaves on the link output that the table entry for its destination names. Its header hop count is raised by one, and stays put when it is already all ones.
- R4: No beat of a packet appears on an output before the packet's last beat has been accepted at its input. The first output beat comes at least two clock edges after that last input handshake.
- R5: The class of a packet is min(hop, NCLASS-1), and each input has one slot per class. in_ready for a header is high only when that input's slot for that class is empty. A full slot of one class does not block headers of another class.
- R6: Once a header has been accepted, in_ready stays high for every remaining beat of that packet.
- R7: Each output takes inputs in round-robin order. After input i wins, the search for the next packet starts at input i+1 and wraps around.
- R8: When one input holds several full slots for the same output, its highest class goes first.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged on the next cycle.
- R10: When cfg_we is high at a clock edge, the entry for cfg_dest takes the value of cfg_port. Packets granted after that edge follow the new entry.
- R11: While rst_n is low, every out_valid is low, all slots empty and every table entry points to link 0. After release, in_ready is high on every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| node_id | input | ID_W | Number of this node |
| cfg_we | input | 1 | Table write strobe |
| cfg_dest | input | ID_W | Destination entry to write |
| cfg_port | input | clog2(N_LINK) | Link index stored for cfg_dest |
| in_valid | input | N_LINK+1 | Beat present per input (host is the top index) |
| in_data | input | (N_LINK+1)*DATA_W | Input beats, input s at bits [s*DATA_W +: DATA_W] |
| in_ready | output | N_LINK+1 | Node takes the presented beat |
| out_valid | output | N_LINK+1 | Beat present per output (host is the top index) |
| out_data | output | (N_LINK+1)*DATA_W | Output beats, same packing as in_data |
| out_ready | input | N_LINK+1 | Receiver takes the presented beat |

## Verification
Two jobs can fall due on the same output in the same cycle. One is the round-robin choice between inputs. The other is the choice of class within one input. The bench stalls a link output behind a host packet it has already granted. It then fills two class slots on one neighbour input and one slot on another, and releases the output. The resulting order must switch inputs on each grant and take the higher class first. It is judged from a log of source and hop fields in the delivered headers, together with the scoreboard comparing every packet against its expected form and route.

// File: rtl/router_pkg.sv
package router_pkg;

  typedef enum logic {
    EG_IDLE = 1'b0,
    EG_SEND = 1'b1
  } eg_state_t;

  function automatic int unsigned width_of(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rtr_rr_arb.sv
module rtr_rr_arb
  import router_pkg::*;
#(
  parameter int N = 3,
  localparam int W = width_of(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [W-1:0] grant,
  output logic         any
);

  logic [W-1:0] ptr;

  always_comb begin
    any   = 1'b0;
    grant = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= N) j = j - N;
      if (!any && req[j]) begin
        any   = 1'b1;
        grant = W'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (int'(grant) == N - 1) ? '0 : grant + 1'b1;
    end
  end

endmodule

// File: rtl/rtr_ingress.sv
module rtr_ingress
  import router_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ID_W      = 3,
  parameter int HOP_W     = 3,
  parameter int NCLASS    = 2,
  parameter int PKT_BEATS = 4,
  localparam int CLS_W     = width_of(NCLASS),
  localparam int BEAT_W    = width_of(PKT_BEATS),
  localparam int SLOT_BITS = PKT_BEATS * DATA_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [DATA_W-1:0]             in_data,
  output logic                          in_ready,
  input  logic [NCLASS-1:0]             slot_rel,
  output logic [NCLASS-1:0]             slot_done,
  output logic [NCLASS*ID_W-1:0]        slot_dest,
  output logic [NCLASS*SLOT_BITS-1:0]   slot_mem
);

  logic [NCLASS-1:0] busy, set_busy, set_done;
  logic              filling;
  logic [CLS_W-1:0]  cur_cls, hdr_cls, wr_cls;
  logic [BEAT_W-1:0] beat_cnt, wr_beat;
  logic [HOP_W-1:0]  hdr_hop;
  logic              accept, last;

  // class is the hop count so far, capped at the top class
  assign hdr_hop = in_data[ID_W +: HOP_W];
  assign hdr_cls = (int'(hdr_hop) >= NCLASS - 1) ? CLS_W'(NCLASS - 1) : CLS_W'(hdr_hop);

  assign wr_cls   = filling ? cur_cls : hdr_cls;
  assign wr_beat  = filling ? beat_cnt : '0;
  assign last     = (wr_beat == BEAT_W'(PKT_BEATS - 1));
  assign in_ready = filling | ~busy[hdr_cls];
  assign accept   = in_valid & in_ready;

  always_comb begin
    set_busy = '0;
    set_done = '0;
    set_busy[hdr_cls] = accept & ~filling;
    set_done[wr_cls]  = accept & last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= '0;
      slot_done <= '0;
      filling   <= 1'b0;
      cur_cls   <= '0;
      beat_cnt  <= '0;
    end else begin
      busy      <= (busy & ~slot_rel) | set_busy;
      slot_done <= (slot_done & ~slot_rel) | set_done;
      if (accept) begin
        if (!filling) cur_cls <= hdr_cls;
        if (last) begin
          filling  <= 1'b0;
          beat_cnt <= '0;
        end else begin
          filling  <= 1'b1;
          beat_cnt <= wr_beat + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      slot_mem[(int'(wr_cls) * PKT_BEATS + int'(wr_beat)) * DATA_W +: DATA_W] <= in_data;
    end
  end

  for (genvar c = 0; c < NCLASS; c++) begin : g_dest
    assign slot_dest[c*ID_W +: ID_W] = slot_mem[c*SLOT_BITS +: ID_W];
  end

endmodule

// File: rtl/rtr_egress.sv
module rtr_egress
  import router_pkg::*;
#(
  parameter int NSRC      = 3,
  parameter int NCLASS    = 2,
  parameter int PKT_BEATS = 4,
  parameter int DATA_W    = 16,
  parameter int ID_W      = 3,
  parameter int HOP_W     = 3,
  parameter bit BUMP_HOP  = 1'b1,
  localparam int SRC_W     = width_of(NSRC),
  localparam int CLS_W     = width_of(NCLASS),
  localparam int BEAT_W    = width_of(PKT_BEATS),
  localparam int SLOT_BITS = PKT_BEATS * DATA_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NSRC*NCLASS-1:0]            req,
  input  logic [NSRC*NCLASS*SLOT_BITS-1:0]  slot_mem_all,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [DATA_W-1:0]                 out_data,
  output logic [NSRC*NCLASS-1:0]            rel
);

  eg_state_t         state;
  logic [NSRC-1:0]   src_req;
  logic [SRC_W-1:0]  grant, sel_src;
  logic [CLS_W-1:0]  pick_cls, sel_cls;
  logic [BEAT_W-1:0] beat;
  logic              any, take, last;
  logic [DATA_W-1:0] raw;

  for (genvar s = 0; s < NSRC; s++) begin : g_req
    assign src_req[s] = |req[s*NCLASS +: NCLASS];
  end

  rtr_rr_arb #(.N(NSRC)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (src_req),
    .adv   (take),
    .grant (grant),
    .any   (any)
  );

  // highest waiting class of the winning input
  always_comb begin
    pick_cls = '0;
    for (int c = 0; c < NCLASS; c++) begin
      if (req[int'(grant) * NCLASS + c]) pick_cls = CLS_W'(c);
    end
  end

  assign take      = (state == EG_IDLE) & any;
  assign out_valid = (state == EG_SEND);
  assign last      = (beat == BEAT_W'(PKT_BEATS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= EG_IDLE;
      sel_src <= '0;
      sel_cls <= '0;
      beat    <= '0;
    end else if (take) begin
      state   <= EG_SEND;
      sel_src <= grant;
      sel_cls <= pick_cls;
      beat    <= '0;
    end else if (out_valid && out_ready) begin
      if (last) state <= EG_IDLE;
      else      beat  <= beat + 1'b1;
    end
  end

  always_comb begin
    raw = slot_mem_all[((int'(sel_src) * NCLASS + int'(sel_cls)) * PKT_BEATS + int'(beat)) * DATA_W +: DATA_W];
  end

  always_comb begin
    rel = '0;
    rel[int'(sel_src) * NCLASS + int'(sel_cls)] = out_valid & out_ready & last;
  end

  if (BUMP_HOP) begin : g_bump
    logic [HOP_W-1:0] hop;
    assign hop = raw[ID_W +: HOP_W];
    always_comb begin
      out_data = raw;
      if (beat == '0) out_data[ID_W +: HOP_W] = (&hop) ? hop : hop + 1'b1;
    end
  end else begin : g_pass
    assign out_data = raw;
  end

endmodule

// File: rtl/router_node.sv
module router_node
  import router_pkg::*;
#(
  parameter int N_LINK    = 2,
  parameter int NCLASS    = 2,
  parameter int PKT_BEATS = 4,
  parameter int DATA_W    = 16,
  parameter int ID_W      = 3,
  parameter int HOP_W     = 3,
  localparam int NSRC      = N_LINK + 1,
  localparam int PORT_W    = width_of(N_LINK),
  localparam int OUT_W     = width_of(NSRC),
  localparam int NNODE     = 1 << ID_W,
  localparam int SLOT_BITS = PKT_BEATS * DATA_W,
  localparam int NSLOT     = NSRC * NCLASS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ID_W-1:0]          node_id,
  input  logic                     cfg_we,
  input  logic [ID_W-1:0]          cfg_dest,
  input  logic [PORT_W-1:0]        cfg_port,
  input  logic [NSRC-1:0]          in_valid,
  input  logic [NSRC*DATA_W-1:0]   in_data,
  output logic [NSRC-1:0]          in_ready,
  output logic [NSRC-1:0]          out_valid,
  output logic [NSRC*DATA_W-1:0]   out_data,
  input  logic [NSRC-1:0]          out_ready
);

  logic [PORT_W-1:0]          nh [NNODE];
  logic [NSLOT-1:0]           slot_done_all, rel_all;
  logic [NSLOT*ID_W-1:0]      slot_dest_all;
  logic [NSLOT*SLOT_BITS-1:0] slot_mem_all;
  logic [NSLOT-1:0]           req_by_out [NSRC];
  logic [NSLOT-1:0]           rel_by_out [NSRC];

  // next-hop table
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < NNODE; d++) nh[d] <= '0;
    end else if (cfg_we) begin
      nh[cfg_dest] <= cfg_port;
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_in
    rtr_ingress #(
      .DATA_W(DATA_W), .ID_W(ID_W), .HOP_W(HOP_W),
      .NCLASS(NCLASS), .PKT_BEATS(PKT_BEATS)
    ) u_in (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid[s]),
      .in_data   (in_data[s*DATA_W +: DATA_W]),
      .in_ready  (in_ready[s]),
      .slot_rel  (rel_all[s*NCLASS +: NCLASS]),
      .slot_done (slot_done_all[s*NCLASS +: NCLASS]),
      .slot_dest (slot_dest_all[s*NCLASS*ID_W +: NCLASS*ID_W]),
      .slot_mem  (slot_mem_all[s*NCLASS*SLOT_BITS +: NCLASS*SLOT_BITS])
    );
  end

  // route each full slot: own node goes to the host output
  always_comb begin
    for (int o = 0; o < NSRC; o++) req_by_out[o] = '0;
    for (int i = 0; i < NSLOT; i++) begin
      logic [ID_W-1:0]  d;
      logic [OUT_W-1:0] tgt;
      d   = slot_dest_all[i*ID_W +: ID_W];
      tgt = (d == node_id) ? OUT_W'(N_LINK) : OUT_W'(nh[d]);
      for (int o = 0; o < NSRC; o++) begin
        req_by_out[o][i] = slot_done_all[i] && (int'(tgt) == o);
      end
    end
  end

  always_comb begin
    rel_all = '0;
    for (int o = 0; o < NSRC; o++) rel_all = rel_all | rel_by_out[o];
  end

  for (genvar o = 0; o < NSRC; o++) begin : g_out
    rtr_egress #(
      .NSRC(NSRC), .NCLASS(NCLASS), .PKT_BEATS(PKT_BEATS),
      .DATA_W(DATA_W), .ID_W(ID_W), .HOP_W(HOP_W),
      .BUMP_HOP(o < N_LINK)
    ) u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (req_by_out[o]),
      .slot_mem_all (slot_mem_all),
      .out_valid    (out_valid[o]),
      .out_ready    (out_ready[o]),
      .out_data     (out_data[o*DATA_W +: DATA_W]),
      .rel          (rel_by_out[o])
    );
  end

endmodule

// File: rtl/rtr_node_chk.sv
module rtr_node_chk
  import router_pkg::*;
#(
  parameter int N_LINK    = 2,
  parameter int PKT_BEATS = 4,
  parameter int DATA_W    = 16,
  parameter int ID_W      = 3,
  parameter int HOP_W     = 3,
  localparam int NSRC   = N_LINK + 1,
  localparam int BEAT_W = width_of(PKT_BEATS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ID_W-1:0]        node_id,
  input logic [NSRC-1:0]        in_valid,
  input logic [NSRC-1:0]        in_ready,
  input logic [NSRC-1:0]        out_valid,
  input logic [NSRC*DATA_W-1:0] out_data,
  input logic [NSRC-1:0]        out_ready
);

  logic [BEAT_W-1:0] in_cnt  [NSRC];
  logic [BEAT_W-1:0] out_cnt [NSRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NSRC; p++) begin
        in_cnt[p]  <= '0;
        out_cnt[p] <= '0;
      end
    end else begin
      for (int p = 0; p < NSRC; p++) begin
        if (in_valid[p] && in_ready[p])
          in_cnt[p] <= (in_cnt[p] == BEAT_W'(PKT_BEATS - 1)) ? '0 : in_cnt[p] + 1'b1;
        if (out_valid[p] && out_ready[p])
          out_cnt[p] <= (out_cnt[p] == BEAT_W'(PKT_BEATS - 1)) ? '0 : out_cnt[p] + 1'b1;
      end
    end
  end

  p_reset_idle_r11: assert property (@(posedge clk) !rst_n |=> (out_valid == '0));

  p_host_dest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid[N_LINK] && out_cnt[N_LINK] == '0) |-> (out_data[N_LINK*DATA_W +: ID_W] == node_id));

  for (genvar p = 0; p < NSRC; p++) begin : g_chk
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[p] && !out_ready[p]) |=> (out_valid[p] && $stable(out_data[p*DATA_W +: DATA_W])));

    p_body_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_cnt[p] != '0) |-> in_ready[p]);

    if (p < N_LINK) begin : g_link
      p_link_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[p] && out_cnt[p] == '0) |->
          ((out_data[p*DATA_W +: ID_W] != node_id) && (out_data[p*DATA_W + ID_W +: HOP_W] != '0)));
    end
  end

endmodule

bind router_node rtr_node_chk #(
  .N_LINK(N_LINK), .PKT_BEATS(PKT_BEATS), .DATA_W(DATA_W), .ID_W(ID_W), .HOP_W(HOP_W)
) i_rtr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .node_id   (node_id),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready)
);

// File: tb/test_router_node.sv
module test_router_node;
  localparam int NL = 2, NS = 3, PB = 4, DW = 16;
  localparam logic [2:0] MY_ID = 3'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_dest = '0;
  logic [0:0] cfg_port = '0;
  logic [NS-1:0] in_valid, in_ready, out_valid, out_rdy;
  logic [NS*DW-1:0] in_data, out_data;
  logic [NS-1:0] iv_r = '0;
  logic [DW-1:0] id_r [NS];

  always #2 clk = ~clk;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      in_valid[s] = iv_r[s];
      in_data[s*DW +: DW] = id_r[s];
    end
  end

  router_node i_router_node (
    .clk(clk), .rst_n(rst_n), .node_id(MY_ID),
    .cfg_we(cfg_we), .cfg_dest(cfg_dest), .cfg_port(cfg_port),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_rdy)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int in_last [256];
  int delivered [NS];
  logic [63:0] exp_q [NS][$];
  logic [4:0] log0 [$];
  logic tab [8];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] build(int src, int dest, int hop, int seq);
    logic [63:0] p;
    p[15:0] = {8'(seq), 2'(src), 3'(hop), 3'(dest)};
    for (int k = 1; k < PB; k++) p[k*16 +: 16] = {8'(seq), 8'(k * 29 + src * 5)};
    return p;
  endfunction

  task automatic push_exp(input logic [63:0] p);
    logic [2:0] d, h;
    d = p[2:0];
    h = p[5:3];
    if (d == MY_ID) exp_q[NL].push_back(p);
    else begin
      p[5:3] = (h == 3'd7) ? h : h + 3'd1;
      exp_q[tab[d] ? 1 : 0].push_back(p);
    end
  endtask

  task automatic send(int src, int dest, int hop, int seq, bit push);
    logic [63:0] p;
    int body_wait;
    p = build(src, dest, hop, seq);
    body_wait = 0;
    if (push) push_exp(p);
    for (int k = 0; k < PB; k++) begin
      iv_r[src] = 1'b1;
      id_r[src] = p[k*16 +: 16];
      forever begin
        @(negedge clk);
        if (in_ready[src]) break;
        if (k > 0) body_wait++;
      end
      if (k == PB - 1) in_last[seq] = cyc;
      @(posedge clk);
      #1;
    end
    iv_r[src] = 1'b0;
    chk(body_wait == 0, "R6 body beats stalled", 64'(body_wait), 64'd0);
  endtask

  task automatic cfg_write(int d, int p);
    cfg_we = 1'b1; cfg_dest = 3'(d); cfg_port = 1'(p);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    tab[d] = (p != 0);
  endtask

  task automatic compare(int o, logic [63:0] got, int first);
    int idx;
    idx = -1;
    foreach (exp_q[o][i]) if (idx < 0 && exp_q[o][i][7:6] == got[7:6]) idx = i;
    if (idx < 0) chk(1'b0, (o == NL) ? "R1 R2 unexpected" : "R1 R3 unexpected", got, 64'd0);
    else begin
      chk(exp_q[o][idx] == got, (o == NL) ? "R1 R2 host packet" : "R1 R3 link packet", got, exp_q[o][idx]);
      exp_q[o].delete(idx);
    end
    chk(first > in_last[got[15:8]], "R4 left before fully stored", 64'(first), 64'(in_last[got[15:8]] + 1));
    delivered[o]++;
    if (o == 0) log0.push_back(got[7:3]);
  endtask

  for (genvar o = 0; o < NS; o++) begin : g_mon
    initial begin
      logic [63:0] got;
      int k, first;
      k = 0; first = 0; got = '0;
      forever begin
        @(negedge clk);
        if (rst_n && out_valid[o] && out_rdy[o]) begin
          if (k == 0) first = cyc;
          got[k*16 +: 16] = out_data[o*DW +: DW];
          k++;
          if (k == PB) begin
            k = 0;
            compare(o, got, first);
          end
        end
      end
    end
  end

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk);
      if (exp_q[0].size() == 0 && exp_q[1].size() == 0 && exp_q[2].size() == 0) break;
    end
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'(cyc), 64'd0);
    finish_run();
  end

  initial begin
    bit done41;
    logic [15:0] held;
    int c1;
    out_rdy = '1;
    for (int s = 0; s < NS; s++) begin
      id_r[s] = '0;
      delivered[s] = 0;
    end
    for (int i = 0; i < 256; i++) in_last[i] = 0;
    for (int d = 0; d < 8; d++) tab[d] = 1'b0;
    repeat (4) @(negedge clk);
    chk(out_valid == '0, "R11 outputs idle in reset", 64'(out_valid), 64'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 3'b111, "R11 ready after reset", 64'(in_ready), 64'd7);
    chk(out_valid == '0, "R11 outputs idle after reset", 64'(out_valid), 64'd0);
    @(posedge clk); #1;
    for (int d = 0; d < 8; d++) cfg_write(d, d % 2);

    // basic routes and hop saturation (R2, R3)
    send(2, 3, 0, 1, 1);
    send(2, 4, 0, 2, 1);
    send(2, 5, 0, 3, 1);
    send(0, 3, 2, 4, 1);
    send(1, 6, 7, 5, 1);
    drain();

    // all inputs at once
    fork
      for (int i = 0; i < 6; i++) send(0, (i * 3) % 8, i % 3, 10 + i, 1);
      for (int i = 0; i < 6; i++) send(1, (i * 5 + 1) % 8, i % 2, 20 + i, 1);
      for (int i = 0; i < 6; i++) send(2, (i + 2) % 8, 0, 30 + i, 1);
    join
    drain();

    // class admission and output hold (R5, R9)
    out_rdy[0] = 1'b0;
    send(1, 0, 0, 40, 1);
    repeat (3) @(negedge clk);
    chk(out_valid[0] == 1'b1, "R9 valid held under stall", 64'(out_valid[0]), 64'd1);
    held = out_data[15:0];
    repeat (5) @(negedge clk);
    chk(out_valid[0] && out_data[15:0] == held, "R9 data held under stall", 64'(out_data[15:0]), 64'(held));
    @(posedge clk); #1;
    done41 = 1'b0;
    fork
      begin send(1, 2, 1, 41, 1); done41 = 1'b1; end
    join_none
    repeat (30) @(posedge clk);
    #1;
    chk(done41, "R5 other class admitted", 64'(done41), 64'd1);
    fork
      send(1, 0, 0, 42, 1);
    join_none
    repeat (10) @(negedge clk);
    chk(in_ready[1] == 1'b0, "R5 full class refuses header", 64'(in_ready[1]), 64'd0);
    @(posedge clk); #1;
    out_rdy[0] = 1'b1;
    drain();

    // arbitration order (R7, R8)
    out_rdy[0] = 1'b0;
    log0.delete();
    send(2, 0, 0, 50, 1);
    repeat (3) @(posedge clk); #1;
    push_exp(build(0, 4, 3, 52));
    push_exp(build(1, 6, 0, 53));
    push_exp(build(0, 2, 0, 51));
    send(0, 2, 0, 51, 0);
    send(0, 4, 3, 52, 0);
    send(1, 6, 0, 53, 0);
    repeat (3) @(posedge clk); #1;
    out_rdy[0] = 1'b1;
    drain();
    chk(log0.size() == 4, "R7 packet count on link 0", 64'(log0.size()), 64'd4);
    if (log0.size() == 4) begin
      chk(log0[1] == 5'b00100, "R8 higher class first", 64'(log0[1]), 64'(5'b00100));
      chk(log0[2][4:3] == 2'd1, "R7 next input in turn", 64'(log0[2][4:3]), 64'd1);
      chk(log0[3] == 5'b00001, "R7 R8 lower class last", 64'(log0[3]), 64'(5'b00001));
    end

    // table rewrite (R10)
    c1 = delivered[1];
    cfg_write(6, 1);
    send(2, 6, 0, 60, 1);
    drain();
    chk(delivered[1] == c1 + 1, "R10 rerouted to link 1", 64'(delivered[1]), 64'(c1 + 1));
    cfg_write(6, 0);

    for (int o = 0; o < NS; o++)
      chk(exp_q[o].size() == 0, "R2 R3 all packets delivered", 64'(exp_q[o].size()), 64'd0);
    finish_run();
  end

endmodule